// File: doc/BRIEF.md
# Variable-Latency Sparse Multiply-Accumulate Unit

This unit is a multi-cycle helper for a processor pipeline that computes dot products over pruned weight data. One command word carries four signed 8-bit weights and a second word carries four signed 8-bit activations. The unit builds a mask of the nonzero weights in hardware and feeds only those weight and activation pairs through one shared multiplier, one pair per cycle. Dense operands therefore take four cycles, and sparse operands take as many cycles as they have nonzero weights.

Software starts an operation with a one-cycle `start` strobe and a function code. The unit can add the masked dot product to a 32-bit signed accumulator, clear the accumulator, or copy the accumulator to the result port. While `busy` is high, the unit drops any new start. `done` marks the end of every accepted clear, read or multiply-accumulate operation.

Lane k of an operand is bits [8k+7:8k]. Lanes are consumed in ascending order, and a priority encoder jumps straight to the next lane that is still pending.

Top module: `sparse_mac_seq`

## Requirements
- R1: A multiply-accumulate operation (func 2'b00) adds the signed sum over lanes k=0..3 of weight lane k times activation lane k to the 32-bit signed accumulator. Both lanes are two's-complement bytes at bits [8k+7:8k].
- R2: After an accepted multiply-accumulate, `busy` stays high for exactly N consecutive cycles when N of the four weight bytes are nonzero and N is at least 1.
- R3: An operand whose four weight bytes are all zero keeps `busy` high for exactly one cycle and leaves the accumulator unchanged.
- R4: `done` is high for one cycle, and that cycle is the one right after the last busy cycle. `done` and `busy` are never high together.
- R5: A `start` sampled while `busy` is high has no effect. It changes neither the latency of the running operation nor the accumulator.
- R6: A clear (func 2'b01) zeroes the accumulator and raises `done` in the next cycle without raising `busy`.
- R7: A read (func 2'b10) loads the accumulator into `result` and raises `done` in the next cycle, and it leaves the accumulator unchanged. `result` changes only in a cycle where `done` is high.
- R8: Function code 2'b11 is reserved. It raises neither `busy` nor `done` and leaves the accumulator unchanged.
- R9: A `start` sampled in the cycle where `done` is high is accepted.
- R10: Under reset (`rst_n` low at a clock edge), `busy`, `done`, `result` and the accumulator all become zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command strobe, sampled when idle |
| func | input | 2 | Function code: 00 multiply-accumulate, 01 clear, 10 read, 11 reserved |
| wgt | input | 32 | Four packed signed 8-bit weights |
| act | input | 32 | Four packed signed 8-bit activations |
| busy | output | 1 | Multiply-accumulate in progress |
| done | output | 1 | One-cycle completion marker |
| result | output | 32 | Accumulator value captured by the last read |

## Verification
The two events that can share a cycle are a new command and the completion of a running multiply-accumulate. The bench covers both sides of that boundary.

In the first case, a clear and another multiply-accumulate are presented on every busy cycle, including the final one. The bench then checks that the latency still matches the nonzero count of the first operand and that a later read returns only that operand's contribution.

In the second case, a read is presented in the `done` cycle. It must be accepted, and it must return an accumulator that already includes the pairs just finished.

// File: rtl/sparse_mac_pkg.sv
// Shared definitions for the sparse multiply-accumulate unit.
// Assumes a two-bit function code driven by the issuing pipeline.
package sparse_mac_pkg;
    typedef enum logic [1:0] {
        FN_MAC   = 2'b00,
        FN_CLEAR = 2'b01,
        FN_READ  = 2'b10,
        FN_RSVD  = 2'b11
    } sm_fn_e;
endpackage

// File: rtl/sm_nz_mask.sv
// Builds a per-lane flag that is set where the weight byte is nonzero.
// Assumes LANES lanes of EW bits each, packed with lane 0 in the low bits.
module sm_nz_mask #(
    parameter int LANES = 4,
    parameter int EW    = 8
) (
    input  logic [LANES*EW-1:0] wgt,
    output logic [LANES-1:0]    mask
);
    // One OR-reduction per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign mask[g] = |wgt[g*EW +: EW];
    end
endmodule

// File: rtl/sm_lane_pick.sv
// Priority encoder: selects the lowest pending lane and returns the mask
// with that lane removed. Assumes IDXW is wide enough to index LANES lanes.
module sm_lane_pick #(
    parameter int LANES = 4,
    parameter int IDXW  = 2
) (
    input  logic [LANES-1:0] pend,
    output logic [IDXW-1:0]  idx,
    output logic             hit,
    output logic [LANES-1:0] rest
);
    // Scan from the top lane down so the lowest set lane wins.
    always_comb begin
        idx  = '0;
        hit  = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IDXW'(i);
                hit = 1'b1;
            end
        end
        rest = pend;
        if (hit) rest[idx] = 1'b0;
    end
endmodule

// File: rtl/sm_mac_dp.sv
// Signed multiply-add datapath: sum = acc_in + sext(w * a).
// Assumes AW is at least twice EW so the product fits before extension.
module sm_mac_dp #(
    parameter int EW = 8,
    parameter int AW = 32
) (
    input  logic [EW-1:0] w,
    input  logic [EW-1:0] a,
    input  logic [AW-1:0] acc_in,
    output logic [AW-1:0] sum
);
    localparam int PW = 2 * EW;

    logic signed [PW-1:0] prod;

    // Single shared multiplier followed by sign extension and add.
    always_comb begin
        prod = $signed(w) * $signed(a);
        sum  = acc_in + {{(AW - PW){prod[PW-1]}}, prod};
    end
endmodule

// File: rtl/sparse_mac_seq.sv
// Variable-latency sparse multiply-accumulate unit. It accepts a command
// when idle, captures the operands and a nonzero-weight mask, and then
// accumulates one surviving pair per cycle in ascending lane order.
// Assumes start is a strobe; starts seen while busy are dropped.
module sparse_mac_seq #(
    parameter int LANES = 4,
    parameter int EW    = 8,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          func,
    input  logic [LANES*EW-1:0] wgt,
    input  logic [LANES*EW-1:0] act,
    output logic                busy,
    output logic                done,
    output logic [AW-1:0]       result
);
    import sparse_mac_pkg::*;

    localparam int OPW  = LANES * EW;
    localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1;

    logic [OPW-1:0]   wgt_q, act_q;
    logic [LANES-1:0] pend_q, mask_in, rest;
    logic [IDXW-1:0]  idx;
    logic             hit;
    logic [AW-1:0]    acc_q, sum, res_q;
    logic             busy_q, done_q;
    logic [EW-1:0]    w_sel, a_sel;

    sm_nz_mask #(.LANES(LANES), .EW(EW)) u_mask (
        .wgt  (wgt),
        .mask (mask_in)
    );

    sm_lane_pick #(.LANES(LANES), .IDXW(IDXW)) u_pick (
        .pend (pend_q),
        .idx  (idx),
        .hit  (hit),
        .rest (rest)
    );

    // Route the selected lane's weight and activation to the multiplier.
    always_comb begin
        w_sel = wgt_q[idx*EW +: EW];
        a_sel = act_q[idx*EW +: EW];
    end

    sm_mac_dp #(.EW(EW), .AW(AW)) u_dp (
        .w      (w_sel),
        .a      (a_sel),
        .acc_in (acc_q),
        .sum    (sum)
    );

    // Command acceptance, per-lane stepping, completion and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wgt_q  <= '0;
            act_q  <= '0;
            pend_q <= '0;
            acc_q  <= '0;
            res_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                if (hit) begin
                    acc_q  <= sum;
                    pend_q <= rest;
                end
                if (!hit || rest == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (start) begin
                case (func)
                    FN_MAC: begin
                        wgt_q  <= wgt;
                        act_q  <= act;
                        pend_q <= mask_in;
                        busy_q <= 1'b1;
                    end
                    FN_CLEAR: begin
                        acc_q  <= '0;
                        done_q <= 1'b1;
                    end
                    FN_READ: begin
                        res_q  <= acc_q;
                        done_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign result = res_q;
endmodule

// File: rtl/sparse_mac_seq_chk.sv
// Port-level protocol checker for sparse_mac_seq, attached by bind.
// Assumes the function codes defined in sparse_mac_pkg.
module sparse_mac_seq_chk #(
    parameter int LANES = 4,
    parameter int AW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    func,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] result
);
    logic [7:0] run_q;

    // Count consecutive busy cycles to bound the latency window.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 8'd1;
        else           run_q <= '0;
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q < 8'(LANES))); // R2

    AST_BUSY_NEEDS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start && func == 2'b00)); // R5

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R4

    AST_CLEAR_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && func == 2'b01) |=> (done && !busy)); // R6

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && func == 2'b11) |=> (!done && !busy)); // R8

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R7
endmodule

bind sparse_mac_seq sparse_mac_seq_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .func   (func),
    .busy   (busy),
    .done   (done),
    .result (result)
);

// File: tb/test_sparse_mac_seq.sv
`timescale 1ns/1ps
// Directed bench for sparse_mac_seq: one task per scenario, with a
// reference accumulator kept in the bench.
module test_sparse_mac_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  func;
    logic [31:0] wgt, act;
    logic        busy, done;
    logic [31:0] result;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] ref_acc = '0;

    always #2.5 clk = ~clk;

    sparse_mac_seq i_sparse_mac_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .wgt(wgt), .act(act), .busy(busy), .done(done), .result(result)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] actv, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
        end
    endtask

    function automatic int nz_count(input logic [31:0] w);
        int c = 0;
        for (int k = 0; k < 4; k++) if (w[k*8 +: 8] != 8'd0) c++;
        return c;
    endfunction

    function automatic logic [31:0] dot4(input logic [31:0] w, input logic [31:0] a);
        int s = 0;
        for (int k = 0; k < 4; k++)
            s += int'($signed(w[k*8 +: 8])) * int'($signed(a[k*8 +: 8]));
        return 32'(s);
    endfunction

    // Read scenario: result must equal the reference accumulator (R7).
    task automatic t_read(input string tag);
        @(negedge clk); start = 1'b1; func = 2'b10;
        @(negedge clk); start = 1'b0;
        check(done && !busy, {"R7 read done ", tag}, {30'd0, busy, done}, 32'd1);
        check(result == ref_acc, {"R7 read value ", tag}, result, ref_acc);
    endtask

    // MAC scenario; inj=1 presents starts on every busy cycle (R5),
    // inj=2 presents a read in the done cycle (R9).
    task automatic t_mac(input logic [31:0] w, input logic [31:0] a,
                         input int inj, input string tag);
        int lat = (nz_count(w) == 0) ? 1 : nz_count(w);
        int cnt = 0;
        @(negedge clk); start = 1'b1; func = 2'b00; wgt = w; act = a;
        @(negedge clk); start = 1'b0;
        while (busy && cnt < 8) begin
            if (inj == 1) begin
                start = 1'b1;
                func  = (cnt % 2 == 0) ? 2'b01 : 2'b00;
                wgt   = 32'h7f7f7f7f; act = 32'h7f7f7f7f;
            end
            cnt++;
            @(negedge clk); start = 1'b0;
        end
        ref_acc += dot4(w, a);
        check(cnt == lat, {"R2 busy length ", tag}, 32'(cnt), 32'(lat));
        check(done && !busy, {"R4 done after busy ", tag}, {30'd0, busy, done}, 32'd1);
        if (inj == 2) begin
            start = 1'b1; func = 2'b10;
            @(negedge clk); start = 1'b0;
            check(done && result == ref_acc, {"R9 read in done cycle ", tag}, result, ref_acc);
        end else begin
            @(negedge clk);
            check(!done && !busy, {"R4 done single ", tag}, {30'd0, busy, done}, 32'd0);
        end
    endtask

    // Reset scenario (R10).
    task automatic t_reset();
        rst_n = 1'b0; start = 1'b0; func = 2'b00; wgt = '0; act = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && result == 32'd0, "R10 reset outputs", result, 32'd0);
        rst_n = 1'b1;
        ref_acc = '0;
        t_read("R10 accumulator zero");
    endtask

    // Clear scenario (R6).
    task automatic t_clear();
        @(negedge clk); start = 1'b1; func = 2'b01;
        @(negedge clk); start = 1'b0;
        check(done && !busy, "R6 clear done", {30'd0, busy, done}, 32'd1);
        ref_acc = '0;
        t_read("R6 after clear");
    endtask

    // Reserved code scenario (R8).
    task automatic t_rsvd();
        @(negedge clk); start = 1'b1; func = 2'b11; wgt = 32'h01010101; act = 32'h01010101;
        @(negedge clk); start = 1'b0;
        check(!done && !busy, "R8 reserved quiet", {30'd0, busy, done}, 32'd0);
        t_read("R8 accumulator kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mac(32'h04030201, 32'h05060708, 0, "R1 dense");
        t_read("R1 dense");
        t_mac(32'h00FB0000, 32'h11229911, 0, "R1 single lane");
        t_read("R1 single lane");
        t_mac(32'h80007F00, 32'h7F0080FF, 0, "R1 extremes");
        t_read("R1 extremes");
        t_mac(32'h00000000, 32'h7F7F7F7F, 0, "R3 all zero");
        t_read("R3 all zero unchanged");
        t_mac(32'hFF00FF00, 32'h03020100, 0, "R2 two lanes");
        t_clear();
        t_mac(32'h0A000B0C, 32'h02030405, 1, "R5 starts while busy");
        t_read("R5 no side effect");
        t_mac(32'h01020304, 32'hFEFDFCFB, 2, "R9 back to back");
        t_rsvd();
        t_read("R7 repeat read stable");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_bad);
        $finish;
    end
endmodule